// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is the register and control logic behind one bidirectional I/O port of a small microcontroller. Software reaches it over a simple write-strobe bus and sets three per-pin registers: output data, direction and pull enable. A one-bit control register selects slow falling edges. The block does not drive pads itself. For each pin it produces the digital controls that a pad ring needs: output enable, output value, pull enable and slow-edge enable. It also samples the pin levels for software reads.

Each pin is one of two kinds, chosen by a parameter mask. A push-pull pin drives both levels and has a pull-down that works only while the pin is an input. An open-drain pin can only sink current, and its pull-up stays on whenever it is enabled, whatever the pin's direction. A chosen subset of the open-drain pins supports slow falling edges. When slow mode is on, one designated pin updates its output one clock after the others. Two open-drain bits may share one physical pad, and a flag shows whether the last data write gave them equal values, which is when the shared pad gets full sink strength.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every pad output enable, pull enable and slow enable is 0, `pair_match` is 0, and all four registers read back as 0. Every pin therefore starts as an input.
- R2: A push-pull pin whose direction bit is 1 has its output enable at 1 and its output value equal to its data bit. With the direction bit at 0, the output enable is 0.
- R3: An open-drain pin (a bit set in `OD_MASK`) never drives high. Its output value is always 0, and its output enable is 1 only when the direction bit is 1 and the data bit is 0.
- R4: A push-pull pin has its pull enable at 1 only when its pull bit is 1 and its direction bit is 0.
- R5: An open-drain pin has its pull enable equal to its pull bit, independent of direction.
- R6: The slow enable of pin i is 1 exactly when bit 0 of the control register is 1, pin i is in `SLOW_MASK`, and its direction bit is 1.
- R7: When bit 0 of the control register is 1, the outputs of pin `LATE_PIN` follow a data write one clock later than the other pins. When the bit is 0, they change in the same cycle as the other pins.
- R8: After a write to the data register, `pair_match` is 1 if the written bits `PAIR_A` and `PAIR_B` are equal and 0 if they differ. Writes to other registers leave it unchanged.
- R9: Reading address 0 returns the data bit for pins whose direction is output and the synchronized pin level for input pins. A pin level change becomes visible after two clock edges and not after one.
- R10: The register map is data at address 0, direction at 1, pull enable at 2 and control at 3, with slow mode in bit 0 and zeros in the other bits. A write takes effect on the clock edge where `wr_en` is high. A write to any other address changes nothing, and reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr` |
| pin_in | input | WIDTH | Raw pin levels from the pads |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output value |
| pad_pull | output | WIDTH | Per-pin pull resistor enable |
| pad_slow | output | WIDTH | Per-pin slow falling-edge enable |
| pair_match | output | 1 | Shared-pad bits last written equal |

## Verification
Some properties are checked on every cycle: the reset state at the pads, that an open-drain pin never drives high, that a push-pull pin never pulls while driving, that slow enables stay inside the slow-capable set, and the `pair_match` update after a data write. Other behaviour can only be shown by the bench's scenarios, because it depends on register contents that are not visible at the ports. This includes the one-cycle lag of the late pin when slow mode is on, the read mux choosing between latched data and the synchronized pin, the two-edge synchronizer latency, and the fact that writes to unmapped addresses change nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_DATA = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_PULL = 2;
  localparam int REG_CTL  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3,
  parameter int PAIR_A = 1,
  parameter int PAIR_B = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  data_late_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic              slow_q,
  output logic              pair_q
);
  logic hit_data, hit_dir, hit_pull, hit_ctl;

  assign hit_data = wr_en && (addr == ADDR_W'(REG_DATA));
  assign hit_dir  = wr_en && (addr == ADDR_W'(REG_DIR));
  assign hit_pull = wr_en && (addr == ADDR_W'(REG_PULL));
  assign hit_ctl  = wr_en && (addr == ADDR_W'(REG_CTL));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q      <= '0;
      data_late_q <= '0;
      dir_q       <= '0;
      pull_q      <= '0;
      slow_q      <= 1'b0;
      pair_q      <= 1'b0;
    end else begin
      data_late_q <= data_q;
      if (hit_data) begin
        data_q <= wdata;
        pair_q <= (wdata[PAIR_A] == wdata[PAIR_B]);
      end
      if (hit_dir)  dir_q  <= wdata;
      if (hit_pull) pull_q <= wdata;
      if (hit_ctl)  slow_q <= wdata[0];
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] OD_MASK   = 8'h06,
  parameter logic [WIDTH-1:0] SLOW_MASK = 8'h06,
  parameter int               LATE_PIN  = 2
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] data_late_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic             slow_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pull,
  output logic [WIDTH-1:0] pad_slow
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic d_eff;
    if (i == LATE_PIN) begin : g_late
      assign d_eff = slow_q ? data_late_q[i] : data_q[i];
    end else begin : g_norm
      assign d_eff = data_q[i];
    end

    if (OD_MASK[i]) begin : g_od
      assign pad_oe[i]   = dir_q[i] & ~d_eff;
      assign pad_out[i]  = 1'b0;
      assign pad_pull[i] = pull_q[i];
    end else begin : g_pp
      assign pad_oe[i]   = dir_q[i];
      assign pad_out[i]  = d_eff;
      assign pad_pull[i] = pull_q[i] & ~dir_q[i];
    end

    if (SLOW_MASK[i]) begin : g_slow
      assign pad_slow[i] = slow_q & dir_q[i];
    end else begin : g_fast
      assign pad_slow[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               ADDR_W    = 3,
  parameter logic [WIDTH-1:0] OD_MASK   = 8'h06,
  parameter logic [WIDTH-1:0] SLOW_MASK = 8'h06,
  parameter int               LATE_PIN  = 2,
  parameter int               PAIR_A    = 1,
  parameter int               PAIR_B    = 2,
  parameter int               SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pull,
  output logic [WIDTH-1:0]  pad_slow,
  output logic              pair_match
);
  logic [WIDTH-1:0] data_q, data_late_q, dir_q, pull_q, pin_sync;
  logic             slow_q;

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .data_q(data_q), .data_late_q(data_late_q), .dir_q(dir_q),
    .pull_q(pull_q), .slow_q(slow_q), .pair_q(pair_match)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH), .OD_MASK(OD_MASK), .SLOW_MASK(SLOW_MASK),
                  .LATE_PIN(LATE_PIN)) u_pad (
    .data_q(data_q), .data_late_q(data_late_q), .dir_q(dir_q), .pull_q(pull_q),
    .slow_q(slow_q), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull),
    .pad_slow(pad_slow)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(REG_DATA))      rdata = (dir_q & data_q) | (~dir_q & pin_sync);
    else if (addr == ADDR_W'(REG_DIR))  rdata = dir_q;
    else if (addr == ADDR_W'(REG_PULL)) rdata = pull_q;
    else if (addr == ADDR_W'(REG_CTL))  rdata = {{(WIDTH-1){1'b0}}, slow_q};
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               ADDR_W    = 3,
  parameter logic [WIDTH-1:0] OD_MASK   = 8'h06,
  parameter logic [WIDTH-1:0] SLOW_MASK = 8'h06,
  parameter int               PAIR_A    = 1,
  parameter int               PAIR_B    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_pull,
  input logic [WIDTH-1:0]  pad_slow,
  input logic              pair_match
);
  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!seen_edge)
    $past(rst) |-> (pad_oe == '0 && pad_pull == '0 && pad_slow == '0 && !pair_match));

  assert_od_never_high_R3: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & pad_out & OD_MASK) == '0));

  assert_pp_no_pull_when_driving_R4: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & pad_pull & ~OD_MASK) == '0));

  assert_slow_only_capable_R6: assert property (@(posedge clk) disable iff (rst)
    ((pad_slow & ~SLOW_MASK) == '0));

  assert_pair_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(REG_DATA)) |=>
      (pair_match == ($past(wdata[PAIR_A]) == $past(wdata[PAIR_B]))));
endmodule

bind gpio_port_ctrl gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .OD_MASK(OD_MASK), .SLOW_MASK(SLOW_MASK),
  .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull),
  .pad_slow(pad_slow), .pair_match(pair_match)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int          W      = 8;
  localparam int          AW     = 3;
  localparam logic [W-1:0] ODM   = 8'h06;
  localparam logic [W-1:0] SLM   = 8'h06;
  localparam int          LATE   = 2;
  localparam int          PA     = 1;
  localparam int          PB     = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata, pin_in = '0;
  logic [W-1:0]  pad_oe, pad_out, pad_pull, pad_slow;
  logic          pair_match;

  int n_tests = 0;
  int n_fail  = 0;

  logic [W-1:0] m_data = '0, m_prev = '0, m_dir = '0, m_pull = '0;
  logic         m_slow = 1'b0, m_pair = 1'b0;

  always #4 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull),
    .pad_slow(pad_slow), .pair_match(pair_match)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] eff_data(input logic lagging);
    logic [W-1:0] d = m_data;
    if (lagging && m_slow) d[LATE] = m_prev[LATE];
    return d;
  endfunction

  function automatic logic [W-1:0] exp_oe(input logic [W-1:0] d);
    return (m_dir & ~ODM) | (m_dir & ~d & ODM);
  endfunction

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] d);
    return d & ~ODM;
  endfunction

  function automatic logic [W-1:0] exp_pull();
    return (m_pull & ODM) | (m_pull & ~m_dir & ~ODM);
  endfunction

  function automatic logic [W-1:0] exp_slow();
    return SLM & m_dir & {W{m_slow}};
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    m_prev = m_data;
    case (a)
      3'd0: begin m_data = d; m_pair = (d[PA] == d[PB]); end
      3'd1: m_dir = d;
      3'd2: m_pull = d;
      3'd3: m_slow = d[0];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    m_prev = m_data;
    @(negedge clk);
  endtask

  task automatic check_pads(input string tag, input logic lagging);
    logic [W-1:0] d = eff_data(lagging);
    check({tag, " R2/R3 oe"}, pad_oe, exp_oe(d));
    check({tag, " R2/R3 out"}, pad_out, exp_out(d));
    check({tag, " R4/R5 pull"}, pad_pull, exp_pull());
    check({tag, " R6 slow"}, pad_slow, exp_slow());
    check({tag, " R8 pair"}, {7'b0, pair_match}, {7'b0, m_pair});
  endtask

  task automatic check_reads(input string tag);
    addr = 3'd0; #1;
    check({tag, " R9 data read"}, rdata, (m_dir & m_data) | (~m_dir & pin_in));
    addr = 3'd1; #1; check({tag, " R10 dir read"}, rdata, m_dir);
    addr = 3'd2; #1; check({tag, " R10 pull read"}, rdata, m_pull);
    addr = 3'd3; #1; check({tag, " R10 ctl read"}, rdata, {7'b0, m_slow});
    addr = 3'd6; #1; check({tag, " R10 unmapped read"}, rdata, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 oe in reset", pad_oe, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe", pad_oe, '0);
    check("R1 pull", pad_pull, '0);
    check("R1 slow", pad_slow, '0);
    check("R1 pair", {7'b0, pair_match}, '0);
    check_reads("R1");

    // R4/R5: pulls with all inputs, then all outputs
    bus_write(3'd2, 8'hFF); check_pads("R5 in", 1'b0);
    bus_write(3'd1, 8'hFF); check_pads("R4 out", 1'b0);
    check("R5 od pull kept", pad_pull, ODM);
    // R3: open-drain drives low only for data 0
    bus_write(3'd0, 8'hFF); check_pads("R3 ones", 1'b0);
    check("R3 od released", pad_oe & ODM, '0);
    bus_write(3'd0, 8'h00); idle(); check_pads("R3 zeros", 1'b0);
    check("R3 od sinking", pad_oe & ODM, ODM);

    // R7: late pin with slow mode on
    bus_write(3'd3, 8'h01);
    bus_write(3'd0, 8'hFF);
    check("R7 late pin lags", pad_oe[LATE], 1'b1);
    check("R7 other od updated", pad_oe[PA], 1'b0);
    idle();
    check("R7 late pin caught up", pad_oe[LATE], 1'b0);
    bus_write(3'd3, 8'h00);
    bus_write(3'd0, 8'h00);
    check("R7 no lag when off", pad_oe[LATE], 1'b1);

    // R8: pair flag
    bus_write(3'd0, 8'h02); check("R8 differ", {7'b0, pair_match}, 8'h00);
    bus_write(3'd1, 8'h00); check("R8 unchanged by dir", {7'b0, pair_match}, 8'h00);
    bus_write(3'd0, 8'h06); check("R8 equal", {7'b0, pair_match}, 8'h01);

    // R10: unmapped write changes nothing
    bus_write(3'd5, 8'hA5); idle(); check_pads("R10 unmapped", 1'b0); check_reads("R10");

    // R9: synchronizer latency on inputs
    pin_in = 8'h5A; addr = 3'd0;
    @(posedge clk); @(negedge clk); #1;
    check("R9 not after one edge", rdata, 8'h00);
    @(posedge clk); @(negedge clk); #1;
    check("R9 after two edges", rdata, 8'h5A);

    // Constrained random
    for (int it = 0; it < 300; it++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d;
      pin_in = W'($urandom);
      a = ($urandom % 10 == 0) ? AW'(4 + $urandom % 4) : AW'($urandom % 4);
      d = W'($urandom);
      bus_write(a, d);
      check_pads("rand R7", 1'b1);
      idle();
      check_pads("rand", 1'b0);
      check_reads("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule